// File: doc/BRIEF.md
# Palette Colour Table Loader

This block holds a 256-entry colour lookup table and loads it through a narrow 32-bit register port. Software first writes a palette position to the index register. It then writes colour components one at a time to the colour register. The block steers each component to red, green or blue according to an internal step counter. Once the blue component is written, the step counter wraps and the palette position moves on by one. A whole palette can therefore be streamed as one long run of colour writes after a single index write.

A separate lookup port serves the pixel path. A pixel index is presented on one cycle and the 24-bit colour stored at that position appears on the next. Every component write changes the stored entry straight away, so a partly loaded triplet is already visible on the lookup port. The register port never returns data and accepts only full-word accesses. Any access with a missing byte lane is dropped and reported on a one-cycle error pulse.

Top module: `palette_dac_seq`

## Requirements
- R1: A full-word write at byte offset 0 loads the palette position from write-data bits 31:24 and returns the component step to red.
- R2: A full-word write at byte offset 4 stores write-data bits 31:24 into the component chosen by the step: red at step 0, green at step 1, blue at step 2. After red or green the step advances by one and the position is kept.
- R3: A write of the blue component advances the palette position by one modulo 256 (255 wraps to 0) and returns the step to red.
- R4: Each component write changes the stored entry on its own, without waiting for the rest of the triplet; a lookup issued after that clock edge returns the new component.
- R5: The lookup output is registered. The value of pix_rgb after edge k is {red, green, blue} (red in bits 23:16, blue in bits 7:0) of the entry named by pix_idx at edge k, taken as it stood before any write made at that same edge.
- R6: reg_rdata is zero at all times, whatever access is presented.
- R7: A read or write whose byte enables are not all ones (4'hF) changes neither the position, the step nor any entry. acc_err is high for exactly the one cycle after such an access, and low after every other cycle.
- R8: A full-word write to any byte offset other than 0 or 4, including unaligned ones, changes no state.
- R9: After reset, entries 0 to 254 read as 24'h000000, entry 255 reads as 24'hFFFFFF, and the position and step are zero.
- R10: Write-data bits 23:0 have no effect on any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_rd | input | 1 | Read strobe for the register port |
| reg_addr | input | 4 | Byte offset within the register window |
| reg_wdata | input | 32 | Write data; only bits 31:24 carry a value |
| reg_be | input | 4 | Byte enables; all four must be set for a legal access |
| reg_rdata | output | 32 | Read data, always zero |
| acc_err | output | 1 | One-cycle pulse after an access with missing byte lanes |
| pix_idx | input | 8 | Pixel index for a colour lookup |
| pix_rgb | output | 24 | Registered colour of the looked-up entry |

## Verification
Four kinds of stimulus are applied. A sweep of all indices straight after reset separates a correct reset image from a table cleared entirely or filled wrongly at the top entry. Directed triplets, with the lookup held on the entry being written, show whether each component lands in the right colour as it arrives and whether the position moves only after blue, including the wrap from 255 to 0. An index write part-way through a triplet, sub-word accesses, and writes to unused offsets between component writes show whether the step and position survive dropped accesses. A long mixed run of random legal and illegal accesses, compared every clock against a behavioural model, catches ordering slips that the directed cases miss.

// File: rtl/pdac_pkg.sv
// Package: shared constants for the palette colour table loader.
// Assumes the component step is two bits wide and that red, green and blue
// are loaded in that fixed order.
package pdac_pkg;
    localparam logic [1:0] STEP_RED = 2'd0;
    localparam logic [1:0] STEP_GRN = 2'd1;
    localparam logic [1:0] STEP_BLU = 2'd2;
    localparam int         NUM_COMP = 3;
endpackage

// File: rtl/pdac_decode.sv
// Module: pdac_decode
// Decodes the register port into a position-load strobe and a component
// strobe, and registers the sub-word error pulse.
// Assumes a legal access sets every byte enable and that the payload byte
// sits at the top of the write word.
module pdac_decode #(
    parameter int                REG_W     = 32,
    parameter int                AW        = 4,
    parameter int                COMP_W    = 8,
    parameter logic [AW-1:0]     OFS_INDEX = '0,
    parameter logic [AW-1:0]     OFS_COLOR = AW'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [AW-1:0]     addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W/8-1:0] be,
    output logic              pos_load,
    output logic              comp_load,
    output logic [COMP_W-1:0] payload,
    output logic              err_q
);
    localparam int BE_W = REG_W / 8;

    logic full_word;
    logic bad_acc;
    logic unused_low;

    // Purpose: qualify the access width and split the strobe by offset.
    always_comb begin
        full_word = (be == {BE_W{1'b1}});
        bad_acc   = (wr || rd) && !full_word;
        pos_load  = wr && full_word && (addr == OFS_INDEX);
        comp_load = wr && full_word && (addr == OFS_COLOR);
        payload   = wdata[REG_W-1 -: COMP_W];
    end

    assign unused_low = ^wdata[REG_W-COMP_W-1:0];

    // Purpose: flag a sub-word access on the cycle after it is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= bad_acc;
    end

    // R8: an access never drives both strobes
    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pos_load, comp_load}));
endmodule

// File: rtl/pdac_seq.sv
// Module: pdac_seq
// Holds the palette position and the red/green/blue step, and turns a
// component strobe into a one-hot write enable for the three colour lanes.
// Assumes the two strobes from the decoder are never high together.
module pdac_seq
    import pdac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pos_load,
    input  logic                comp_load,
    input  logic [IDX_W-1:0]    pos_in,
    output logic [IDX_W-1:0]    pos_q,
    output logic [1:0]          step_q,
    output logic [NUM_COMP-1:0] lane_we
);
    // Purpose: decode the current step into a single lane enable.
    always_comb begin
        lane_we = '0;
        if (comp_load) begin
            for (int c = 0; c < NUM_COMP; c++) begin
                lane_we[c] = (step_q == 2'(c));
            end
        end
    end

    // Purpose: load, hold or advance the position and the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            step_q <= STEP_RED;
        end else if (pos_load) begin
            pos_q  <= pos_in;
            step_q <= STEP_RED;
        end else if (comp_load) begin
            if (step_q == STEP_BLU) begin
                pos_q  <= pos_q + 1'b1;
                step_q <= STEP_RED;
            end else begin
                step_q <= step_q + 2'd1;
            end
        end
    end

    // R1: a position load takes the payload and restarts at red
    assert_pos_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pos_load |=> (pos_q == $past(pos_in)) && (step_q == STEP_RED));

    // R2: red and green advance the step and keep the position
    assert_step_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_load && step_q != STEP_BLU) |=>
            (step_q == $past(step_q) + 2'd1) && $stable(pos_q));

    // R2: the step never reaches its unused code
    assert_step_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_q != 2'd3);

    // R3: blue moves the position on by one and restarts at red
    assert_blue_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_load && step_q == STEP_BLU) |=>
            (pos_q == $past(pos_q) + 1'b1) && (step_q == STEP_RED));
endmodule

// File: rtl/pdac_lane.sv
// Module: pdac_lane
// One colour component of the palette: a resettable array with one write
// port and a registered lookup port.
// Assumes the lookup samples the array as it stood before a same-edge write.
module pdac_lane #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [COMP_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [COMP_W-1:0] rdata_q
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [COMP_W-1:0] mem [ENTRIES];

    // Purpose: reset to black with a white top entry, else take the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= (i == ENTRIES - 1) ? {COMP_W{1'b1}} : '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Purpose: register the looked-up component for the pixel path.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= mem[raddr];
    end

    // R4: a component write lands in its entry at the same edge
    assert_lane_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/palette_dac_seq.sv
// Module: palette_dac_seq (top)
// Palette colour table with a sequenced component loader and a registered
// pixel lookup. Assumes full-word register accesses; anything narrower is
// dropped and flagged on acc_err.
module palette_dac_seq
    import pdac_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int AW     = 4,
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [AW-1:0]            reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    input  logic [REG_W/8-1:0]       reg_be,
    output logic [REG_W-1:0]         reg_rdata,
    output logic                     acc_err,
    input  logic [IDX_W-1:0]         pix_idx,
    output logic [NUM_COMP*COMP_W-1:0] pix_rgb
);
    logic                pos_load;
    logic                comp_load;
    logic [COMP_W-1:0]   payload;
    logic [IDX_W-1:0]    pos_q;
    logic [1:0]          step_q;
    logic [NUM_COMP-1:0] lane_we;

    pdac_decode #(
        .REG_W  (REG_W),
        .AW     (AW),
        .COMP_W (COMP_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .be        (reg_be),
        .pos_load  (pos_load),
        .comp_load (comp_load),
        .payload   (payload),
        .err_q     (acc_err)
    );

    pdac_seq #(
        .IDX_W (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos_load  (pos_load),
        .comp_load (comp_load),
        .pos_in    (payload[COMP_W-1 -: IDX_W]),
        .pos_q     (pos_q),
        .step_q    (step_q),
        .lane_we   (lane_we)
    );

    // Purpose: one lane per colour; lane 0 (red) feeds the top field.
    for (genvar c = 0; c < NUM_COMP; c++) begin : g_lane
        pdac_lane #(
            .IDX_W  (IDX_W),
            .COMP_W (COMP_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (lane_we[c]),
            .waddr   (pos_q),
            .wdata   (payload),
            .raddr   (pix_idx),
            .rdata_q (pix_rgb[(NUM_COMP-1-c)*COMP_W +: COMP_W])
        );
    end

    // Purpose: the register port never returns data.
    assign reg_rdata = '0;

    // R7: the edge that raised the error pulse changed no sequencer state
    assert_err_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $stable(pos_q) && $stable(step_q));

    // R7: no lane is written by a sub-word access
    assert_err_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && !(&reg_be)) |-> (lane_we == '0));
endmodule

// File: tb/sim_palette_dac_seq.sv
module sim_palette_dac_seq;
    localparam int CLK_PER = 10;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_rdata;
    logic        acc_err;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    palette_dac_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
        .reg_rdata(reg_rdata), .acc_err(acc_err),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    always #(CLK_PER/2) clk = ~clk;

    int total = 0, bad = 0, cycles = 0;
    bit chk_on = 0, done = 0;
    string cur_req = "R9";

    // behavioural reference
    bit [7:0]  m_r [256];
    bit [7:0]  m_g [256];
    bit [7:0]  m_b [256];
    int        m_pos = 0, m_step = 0;
    bit [23:0] e_rgb = '0;
    bit        e_err = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit sub;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                m_r[i] = (i == 255) ? 8'hFF : 8'h00;
                m_g[i] = m_r[i];
                m_b[i] = m_r[i];
            end
            m_pos = 0; m_step = 0; e_rgb = '0; e_err = 0;
        end else begin
            e_rgb = {m_r[pix_idx], m_g[pix_idx], m_b[pix_idx]};
            sub = (reg_wr || reg_rd) && (reg_be != 4'hF);
            e_err = sub;
            if (reg_wr && !sub) begin
                if (reg_addr == 4'd0) begin
                    m_pos = reg_wdata[31:24]; m_step = 0;
                end else if (reg_addr == 4'd4) begin
                    if (m_step == 0) m_r[m_pos] = reg_wdata[31:24];
                    else if (m_step == 1) m_g[m_pos] = reg_wdata[31:24];
                    else m_b[m_pos] = reg_wdata[31:24];
                    if (m_step == 2) begin m_step = 0; m_pos = (m_pos + 1) % 256; end
                    else m_step = m_step + 1;
                end
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk({cur_req, " lookup"}, {8'h0, pix_rgb}, {8'h0, e_rgb});
            chk("R7 err pulse", {31'h0, acc_err}, {31'h0, e_err});
            chk("R6 rdata", reg_rdata, 32'h0);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WD_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic op(input bit w, input bit r, input logic [3:0] a,
                      input logic [31:0] d, input logic [3:0] b, input logic [7:0] p);
        @(negedge clk);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; reg_be = b; pix_idx = p;
    endtask

    task automatic idle(input logic [7:0] p);
        op(0, 0, 4'd0, 32'h0, 4'h0, p);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v, input logic [7:0] p);
        op(1, 0, a, {v, 24'h5A_C3_96}, 4'hF, p);
    endtask

    initial begin
        rst_n = 0;
        repeat (3) @(posedge clk);
        chk_on = 1;
        @(negedge clk); rst_n = 1;

        // R9: reset image swept over every entry
        cur_req = "R9";
        for (int i = 0; i < 256; i++) idle(8'(i));
        idle(8'd255);

        // R1 R2 R4 R10: triplet at 0x10 with the lookup held on it
        cur_req = "R2 R4 R10";
        op(1, 0, 4'd0, 32'h10_FF_FF_FF, 4'hF, 8'h10);
        wr(4'd4, 8'h11, 8'h10);
        wr(4'd4, 8'h22, 8'h10);
        wr(4'd4, 8'h33, 8'h10);
        idle(8'h10);
        cur_req = "R3";
        wr(4'd4, 8'h44, 8'h11);
        idle(8'h11); idle(8'h10);

        // R1: position load mid-triplet restarts at red
        cur_req = "R1";
        wr(4'd0, 8'h05, 8'h05);
        wr(4'd4, 8'hAA, 8'h05);
        wr(4'd0, 8'h06, 8'h05);
        wr(4'd4, 8'hBB, 8'h06);
        idle(8'h06); idle(8'h05);

        // R3: wrap from 255 to 0
        cur_req = "R3 wrap";
        wr(4'd0, 8'hFF, 8'hFF);
        wr(4'd4, 8'h01, 8'hFF);
        wr(4'd4, 8'h02, 8'hFF);
        wr(4'd4, 8'h03, 8'hFF);
        wr(4'd4, 8'h77, 8'h00);
        idle(8'h00); idle(8'hFF);

        // R7: sub-word accesses leave step and position alone
        cur_req = "R7";
        wr(4'd0, 8'h40, 8'h40);
        wr(4'd4, 8'h12, 8'h40);
        op(1, 0, 4'd4, 32'hEE000000, 4'h8, 8'h40);
        op(1, 0, 4'd0, 32'h99000000, 4'h7, 8'h40);
        op(0, 1, 4'd4, 32'h0, 4'h1, 8'h40);
        wr(4'd4, 8'h34, 8'h40);
        idle(8'h40);

        // R8: other offsets ignored
        cur_req = "R8";
        wr(4'd8, 8'h55, 8'h40);
        wr(4'd12, 8'h66, 8'h40);
        wr(4'd2, 8'h67, 8'h40);
        wr(4'd5, 8'h68, 8'h40);
        wr(4'd4, 8'h56, 8'h40);
        idle(8'h40); idle(8'h41);

        // R6: full-word reads return zero and change nothing
        cur_req = "R6";
        op(0, 1, 4'd0, 32'h0, 4'hF, 8'h41);
        op(0, 1, 4'd4, 32'h0, 4'hF, 8'h41);
        wr(4'd4, 8'h9C, 8'h41);
        idle(8'h41);

        // R5: write and lookup of the same entry at the same edge
        cur_req = "R5";
        wr(4'd0, 8'h80, 8'h80);
        wr(4'd4, 8'hC1, 8'h80);
        wr(4'd4, 8'hC2, 8'h80);
        idle(8'h80);

        // mixed random traffic
        cur_req = "R2 R3 R7 R8 mixed";
        for (int n = 0; n < 600; n++) begin
            int k;
            logic [3:0] a;
            k = $urandom_range(0, 9);
            a = (k < 6) ? 4'd4 : (k < 8) ? 4'd0 : 4'($urandom_range(0, 15));
            op($urandom_range(0, 5) != 0, $urandom_range(0, 4) == 0, a,
               $urandom, ($urandom_range(0, 6) == 0) ? 4'($urandom) : 4'hF,
               8'($urandom_range(0, 255)));
        end
        idle(8'h00);
        idle(8'h00);

        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule